// File: doc/BRIEF.md
# Undefined Opcode Trap Dispatcher

This unit takes over when the instruction decoder meets an opcode that has no hardware handler. Given the byte-addressed program counter of the trapping instruction and the current top-of-stack pointer, it reads the opcode byte back from word-organised code memory. It then looks the opcode up in a table of two-word entries. The first entry word is the index of the function that emulates the opcode. The second entry word carries the argument count and the number of inline operand bytes that follow the opcode.

When the entry asks for operand bytes, the unit gathers them from code memory and fetches a second code word if they spill past the first. It pushes them onto the stack as one tagged small-integer cell: a tag word followed by the value word. It then hands the call engine a one-cycle result carrying the function index, argument count, return PC and the updated top-of-stack pointer. An entry with an operand count above two ends the trap with an error pulse and leaves the stack untouched.

The trap request, the read port (code and table share it) and the stack write port all use valid/ready handshakes. A request is taken when `trap_valid` and `trap_ready` are both high. Reads and writes are held with stable address, select and data until `rd_ready` or `wr_ready` is seen high at a clock edge. A read's data returns later on `rsp_valid`, in the order the reads were issued. The result and error outputs are plain pulses.

Top module: `uotd_dispatch`

## Requirements
- R1: After reset the unit is idle: `trap_ready` is 1, and `rd_valid`, `wr_valid`, `done` and `err` are 0.
- R2: The opcode is taken from code word `trap_pc >> 1`. When bit 0 of the PC is 0 it is the high byte (bits 15:8) of that word. When bit 0 is 1 it is the low byte (bits 7:0).
- R3: The table is read with `rd_sel`=1, first at word address 2×opcode and then at 2×opcode+1. `fn_index` equals the first word. `arg_count` equals bits 7:0 of the second word.
- R4: If bits 15:8 of the second table word are 0, no stack write is made and `new_tos` equals `trap_tos`.
- R5: With an operand count of 1, the unit writes the tag word `SMALL_TAG` (default 0x000E) at `trap_tos`. It then writes the byte at PC+1, zero-extended, at `trap_tos`+1. `new_tos` is `trap_tos`+2.
- R6: With an operand count of 2, the value word is {byte at PC+1, byte at PC+2}. The byte at PC+1 forms bits 15:8.
- R7: A second code read at word `(trap_pc>>1)+1` is made exactly when an operand byte lies in it: an odd PC with count 1 or 2, or an even PC with count 2. Otherwise only one code read is made.
- R8: `ret_pc` equals `trap_pc` + 1 + operand count.
- R9: An operand count above 2 gives a one-cycle `err` pulse with no `done` and no stack write. `trap_ready` returns to 1 in the following cycle.
- R10: A read or write that is not accepted stays asserted with unchanged address, select and data in the next cycle.
- R11: `done` is a single-cycle pulse, and `trap_ready` is 0 from the cycle after a request is accepted until the trap ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap request |
| trap_ready | output | 1 | Unit idle, request can be taken |
| trap_pc | input | AW+1 | Byte PC of the trapping opcode |
| trap_tos | input | SW | Stack pointer, next free word |
| rd_valid | output | 1 | Read request |
| rd_ready | input | 1 | Read request accepted |
| rd_sel | output | 1 | 0 = code memory, 1 = dispatch table |
| rd_addr | output | AW | Read word address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | DW | Read data |
| wr_valid | output | 1 | Stack write request |
| wr_ready | input | 1 | Stack write accepted |
| wr_addr | output | SW | Stack write word address |
| wr_data | output | DW | Stack write data |
| done | output | 1 | Trap result valid (one cycle) |
| fn_index | output | DW | Function index to call |
| arg_count | output | DW/2 | Argument count for the call |
| ret_pc | output | AW+1 | Byte PC after the operand bytes |
| new_tos | output | SW | Stack pointer after the pushes |
| err | output | 1 | Illegal operand count (one cycle) |

## Verification
A wrong byte selection or table index shows up in the very next table read as an address other than twice the expected opcode. It then shows up in the function index reported at the end of the same trap. A miscounted operand length surfaces within the trap in three ways: an extra or missing code read, a missing or extra pair of stack writes, and a return PC or stack pointer off by the count difference. A control sequence that mishandles a stalled handshake either changes its request while it waits, which the bound checks catch at the following edge, or ends with wrong pushed data, which the directed cases under stalling catch.

// File: rtl/uotd_pkg.sv
package uotd_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_CODE_RQ,
    S_CODE_RSP,
    S_T0_RQ,
    S_T0_RSP,
    S_T1_RQ,
    S_T1_RSP,
    S_X_RQ,
    S_X_RSP,
    S_TAG_WR,
    S_VAL_WR,
    S_DONE,
    S_ERR
  } seq_state_t;

  localparam int MAX_OPERANDS = 2;
endpackage

// File: rtl/uotd_byte_pick.sv
module uotd_byte_pick #(
  parameter int DW = 16,
  localparam int BW = DW / 2
) (
  input  logic [DW-1:0] word_i,
  input  logic          odd_i,
  output logic [BW-1:0] byte_o
);
  // even byte address sits in the upper half of the word
  assign byte_o = odd_i ? word_i[BW-1:0] : word_i[DW-1:BW];
endmodule

// File: rtl/uotd_operand_build.sv
module uotd_operand_build #(
  parameter int DW = 16,
  localparam int BW = DW / 2
) (
  input  logic [DW-1:0] w0_i,
  input  logic [DW-1:0] w1_i,
  input  logic          pc_odd_i,
  input  logic          two_i,
  output logic [DW-1:0] value_o
);
  logic [BW-1:0] first_b;
  logic [BW-1:0] second_b;
  logic [DW-1:0] first_src;

  // byte at PC+1: low half of w0 for an even PC, high half of w1 for an odd PC
  assign first_src = pc_odd_i ? w1_i : w0_i;

  uotd_byte_pick #(.DW(DW)) pick_first_i (
    .word_i (first_src),
    .odd_i  (~pc_odd_i),
    .byte_o (first_b)
  );

  // byte at PC+2 always lives in w1
  uotd_byte_pick #(.DW(DW)) pick_second_i (
    .word_i (w1_i),
    .odd_i  (pc_odd_i),
    .byte_o (second_b)
  );

  assign value_o = two_i ? {first_b, second_b} : {{BW{1'b0}}, first_b};
endmodule

// File: rtl/uotd_seq.sv
module uotd_seq
  import uotd_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 16,
  parameter int SW = 16,
  parameter logic [DW-1:0] SMALL_TAG = 16'h000E,
  localparam int PCW  = AW + 1,
  localparam int BW   = DW / 2,
  localparam int TPAD = AW - BW - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trap_valid,
  output logic           trap_ready,
  input  logic [PCW-1:0] trap_pc,
  input  logic [SW-1:0]  trap_tos,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic           rd_sel,
  output logic [AW-1:0]  rd_addr,
  input  logic           rsp_valid,
  input  logic [DW-1:0]  rsp_data,
  output logic           wr_valid,
  input  logic           wr_ready,
  output logic [SW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data,
  input  logic [BW-1:0]  opcode_i,
  input  logic [DW-1:0]  operand_i,
  output logic [DW-1:0]  w0_o,
  output logic [DW-1:0]  w1_o,
  output logic           pc_odd_o,
  output logic           two_o,
  output logic           done,
  output logic [DW-1:0]  fn_index,
  output logic [BW-1:0]  arg_count,
  output logic [PCW-1:0] ret_pc,
  output logic [SW-1:0]  new_tos,
  output logic           err
);
  seq_state_t     state_q;
  logic [PCW-1:0] pc_q;
  logic [SW-1:0]  tos_q;
  logic [DW-1:0]  w0_q;
  logic [DW-1:0]  w1_q;
  logic [DW-1:0]  fn_q;
  logic [BW-1:0]  arg_q;
  logic [1:0]     nops_q;

  logic [BW-1:0]  cnt_field;
  logic           cnt_bad;
  logic           cnt_zero;
  logic           need_x;
  logic [AW-1:0]  code_word;

  assign cnt_field = rsp_data[DW-1:BW];
  assign cnt_bad   = cnt_field > BW'(MAX_OPERANDS);
  assign cnt_zero  = cnt_field == '0;
  // second word needed when any operand byte lands past the first word
  assign need_x    = pc_q[0] ? !cnt_zero : (cnt_field == BW'(2));
  assign code_word = pc_q[PCW-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
      tos_q   <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      fn_q    <= '0;
      arg_q   <= '0;
      nops_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (trap_valid) begin
          pc_q    <= trap_pc;
          tos_q   <= trap_tos;
          w1_q    <= '0;
          state_q <= S_CODE_RQ;
        end
        S_CODE_RQ:  if (rd_ready) state_q <= S_CODE_RSP;
        S_CODE_RSP: if (rsp_valid) begin
          w0_q    <= rsp_data;
          state_q <= S_T0_RQ;
        end
        S_T0_RQ:    if (rd_ready) state_q <= S_T0_RSP;
        S_T0_RSP:   if (rsp_valid) begin
          fn_q    <= rsp_data;
          state_q <= S_T1_RQ;
        end
        S_T1_RQ:    if (rd_ready) state_q <= S_T1_RSP;
        S_T1_RSP:   if (rsp_valid) begin
          arg_q  <= rsp_data[BW-1:0];
          nops_q <= cnt_field[1:0];
          if (cnt_bad)       state_q <= S_ERR;
          else if (cnt_zero) state_q <= S_DONE;
          else if (need_x)   state_q <= S_X_RQ;
          else               state_q <= S_TAG_WR;
        end
        S_X_RQ:     if (rd_ready) state_q <= S_X_RSP;
        S_X_RSP:    if (rsp_valid) begin
          w1_q    <= rsp_data;
          state_q <= S_TAG_WR;
        end
        S_TAG_WR:   if (wr_ready) state_q <= S_VAL_WR;
        S_VAL_WR:   if (wr_ready) state_q <= S_DONE;
        S_DONE:     state_q <= S_IDLE;
        S_ERR:      state_q <= S_IDLE;
        default:    state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_valid = 1'b0;
    rd_sel   = 1'b0;
    rd_addr  = code_word;
    case (state_q)
      S_CODE_RQ: rd_valid = 1'b1;
      S_T0_RQ: begin
        rd_valid = 1'b1;
        rd_sel   = 1'b1;
        rd_addr  = {{TPAD{1'b0}}, opcode_i, 1'b0};
      end
      S_T1_RQ: begin
        rd_valid = 1'b1;
        rd_sel   = 1'b1;
        rd_addr  = {{TPAD{1'b0}}, opcode_i, 1'b1};
      end
      S_X_RQ: begin
        rd_valid = 1'b1;
        rd_addr  = code_word + AW'(1);
      end
      default: ;
    endcase
  end

  assign wr_valid   = (state_q == S_TAG_WR) || (state_q == S_VAL_WR);
  assign wr_addr    = (state_q == S_VAL_WR) ? tos_q + SW'(1) : tos_q;
  assign wr_data    = (state_q == S_VAL_WR) ? operand_i : SMALL_TAG;

  assign trap_ready = state_q == S_IDLE;
  assign done       = state_q == S_DONE;
  assign err        = state_q == S_ERR;
  assign fn_index   = fn_q;
  assign arg_count  = arg_q;
  assign ret_pc     = pc_q + PCW'(1) + PCW'(nops_q);
  assign new_tos    = (nops_q != 2'd0) ? tos_q + SW'(2) : tos_q;

  assign w0_o     = w0_q;
  assign w1_o     = w1_q;
  assign pc_odd_o = pc_q[0];
  assign two_o    = nops_q == 2'd2;
endmodule

// File: rtl/uotd_dispatch.sv
module uotd_dispatch #(
  parameter int AW = 15,
  parameter int DW = 16,
  parameter int SW = 16,
  parameter logic [DW-1:0] SMALL_TAG = 16'h000E,
  localparam int PCW = AW + 1,
  localparam int BW  = DW / 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trap_valid,
  output logic           trap_ready,
  input  logic [PCW-1:0] trap_pc,
  input  logic [SW-1:0]  trap_tos,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic           rd_sel,
  output logic [AW-1:0]  rd_addr,
  input  logic           rsp_valid,
  input  logic [DW-1:0]  rsp_data,
  output logic           wr_valid,
  input  logic           wr_ready,
  output logic [SW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic           done,
  output logic [DW-1:0]  fn_index,
  output logic [BW-1:0]  arg_count,
  output logic [PCW-1:0] ret_pc,
  output logic [SW-1:0]  new_tos,
  output logic           err
);
  logic [DW-1:0] w0;
  logic [DW-1:0] w1;
  logic          pc_odd;
  logic          two;
  logic [BW-1:0] opcode;
  logic [DW-1:0] operand;

  uotd_byte_pick #(.DW(DW)) op_pick_i (
    .word_i (w0),
    .odd_i  (pc_odd),
    .byte_o (opcode)
  );

  uotd_operand_build #(.DW(DW)) operand_i (
    .w0_i     (w0),
    .w1_i     (w1),
    .pc_odd_i (pc_odd),
    .two_i    (two),
    .value_o  (operand)
  );

  uotd_seq #(.AW(AW), .DW(DW), .SW(SW), .SMALL_TAG(SMALL_TAG)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_valid (trap_valid),
    .trap_ready (trap_ready),
    .trap_pc    (trap_pc),
    .trap_tos   (trap_tos),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_sel     (rd_sel),
    .rd_addr    (rd_addr),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .opcode_i   (opcode),
    .operand_i  (operand),
    .w0_o       (w0),
    .w1_o       (w1),
    .pc_odd_o   (pc_odd),
    .two_o      (two),
    .done       (done),
    .fn_index   (fn_index),
    .arg_count  (arg_count),
    .ret_pc     (ret_pc),
    .new_tos    (new_tos),
    .err        (err)
  );
endmodule

// File: rtl/uotd_checker.sv
module uotd_checker #(
  parameter int AW = 15,
  parameter int DW = 16,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trap_valid,
  input logic          trap_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          rd_sel,
  input logic [AW-1:0] rd_addr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [SW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          done,
  input logic          err
);
  // R10: a stalled read keeps its request unchanged
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr) && $stable(rd_sel));

  // R10: a stalled stack write keeps its request unchanged
  a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R11: result is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: busy right after a request is taken
  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && trap_ready |=> !trap_ready);

  // R9: error and result never coincide, and the unit is free again next cycle
  a_r9_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !done && !wr_valid);

  a_r9_err_recover: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> trap_ready);

  // R1/R11: no memory traffic while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ready |-> !rd_valid && !wr_valid);
endmodule

bind uotd_dispatch uotd_checker #(.AW(AW), .DW(DW), .SW(SW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .trap_valid (trap_valid),
  .trap_ready (trap_ready),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_sel     (rd_sel),
  .rd_addr    (rd_addr),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .done       (done),
  .err        (err)
);

// File: tb/uotd_dispatch_tb_top.sv
`timescale 1ns/1ps
module uotd_dispatch_tb_top;
  localparam logic [15:0] TAG = 16'h000E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_valid = 1'b0;
  logic        trap_ready;
  logic [15:0] trap_pc = '0;
  logic [15:0] trap_tos = '0;
  logic        rd_valid, rd_ready, rd_sel;
  logic [14:0] rd_addr;
  logic        rsp_valid = 1'b0;
  logic [15:0] rsp_data = '0;
  logic        wr_valid, wr_ready;
  logic [15:0] wr_addr, wr_data;
  logic        done, err;
  logic [15:0] fn_index;
  logic [7:0]  arg_count;
  logic [15:0] ret_pc, new_tos;

  always #2.5 clk = ~clk;

  uotd_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_ready(trap_ready),
    .trap_pc(trap_pc), .trap_tos(trap_tos), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .fn_index(fn_index), .arg_count(arg_count), .ret_pc(ret_pc),
    .new_tos(new_tos), .err(err)
  );

  // memory models and logs
  logic [15:0] code_mem [0:255];
  logic [15:0] tab_mem  [0:511];
  logic [15:0] ta_log [0:63];
  logic [15:0] wa_log [0:63];
  logic [15:0] wd_log [0:63];
  int code_rd = 0;
  int tab_rd  = 0;
  int wr_n    = 0;
  logic stall = 1'b0;
  logic ph = 1'b0;

  always @(negedge clk) ph <= ~ph;
  assign rd_ready = ~stall | ph;
  assign wr_ready = ~stall | ph;

  always @(posedge clk) begin
    rsp_valid <= rd_valid && rd_ready && rst_n;
    rsp_data  <= rd_sel ? tab_mem[rd_addr[8:0]] : code_mem[rd_addr[7:0]];
    if (rst_n && rd_valid && rd_ready) begin
      if (rd_sel) begin
        ta_log[tab_rd % 64] <= {1'b0, rd_addr};
        tab_rd <= tab_rd + 1;
      end else begin
        code_rd <= code_rd + 1;
      end
    end
    if (rst_n && wr_valid && wr_ready) begin
      wa_log[wr_n % 64] <= wr_addr;
      wd_log[wr_n % 64] <= wr_data;
      wr_n <= wr_n + 1;
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  logic finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // results of the last trap
  logic        g_done, g_err;
  logic [15:0] g_fn, g_ret, g_tos;
  logic [7:0]  g_arg;
  int b_code, b_tab, b_wr;

  task automatic run_trap(input logic [15:0] pc, input logic [15:0] tos);
    @(negedge clk);
    b_code = code_rd; b_tab = tab_rd; b_wr = wr_n;
    chk("R11 ready before request", {31'd0, trap_ready}, 32'd1);
    trap_pc = pc; trap_tos = tos; trap_valid = 1'b1;
    @(negedge clk);
    trap_valid = 1'b0;
    chk("R11 busy after accept", {31'd0, trap_ready}, 32'd0);
    g_done = 1'b0; g_err = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (done || err) begin
        g_done = done; g_err = err; g_fn = fn_index; g_arg = arg_count;
        g_ret = ret_pc; g_tos = new_tos;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic legal_case(input string nm, input logic [15:0] pc, input logic [15:0] tos,
                            input logic [7:0] op, input logic [15:0] fn, input logic [7:0] na,
                            input int nops, input logic [15:0] val, input int reads);
    run_trap(pc, tos);
    $display("case %s", nm);
    chk("R11 done seen", {31'd0, g_done}, 32'd1);
    chk("R2 opcode via table addr", {16'd0, ta_log[b_tab % 64]}, {23'd0, op, 1'b0});
    chk("R3 second table addr", {16'd0, ta_log[(b_tab + 1) % 64]}, {23'd0, op, 1'b1});
    chk("R3 fn_index", {16'd0, g_fn}, {16'd0, fn});
    chk("R3 arg_count", {24'd0, g_arg}, {24'd0, na});
    chk("R8 ret_pc", {16'd0, g_ret}, {16'd0, pc + 16'(1 + nops)});
    chk("R7 code reads", code_rd - b_code, reads);
    if (nops == 0) begin
      chk("R4 no writes", wr_n - b_wr, 0);
      chk("R4 new_tos", {16'd0, g_tos}, {16'd0, tos});
    end else begin
      chk("R5 write count", wr_n - b_wr, 2);
      chk("R5 tag addr", {16'd0, wa_log[b_wr % 64]}, {16'd0, tos});
      chk("R5 tag data", {16'd0, wd_log[b_wr % 64]}, {16'd0, TAG});
      chk("R5 value addr", {16'd0, wa_log[(b_wr + 1) % 64]}, {16'd0, tos + 16'd1});
      chk(nops == 2 ? "R6 value data" : "R5 value data",
          {16'd0, wd_log[(b_wr + 1) % 64]}, {16'd0, val});
      chk("R5 new_tos", {16'd0, g_tos}, {16'd0, tos + 16'd2});
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 ready", {31'd0, trap_ready}, 32'd1);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    chk("R1 wr_valid", {31'd0, wr_valid}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);
  endtask

  task automatic t_illegal;
    b_wr = wr_n;
    @(negedge clk);
    b_wr = wr_n;
    trap_pc = 16'h00C0; trap_tos = 16'h0300; trap_valid = 1'b1;
    @(negedge clk);
    trap_valid = 1'b0;
    g_err = 1'b0; g_done = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (done) g_done = 1'b1;
      if (err) begin g_err = 1'b1; break; end
      @(negedge clk);
    end
    chk("R9 err pulse", {31'd0, g_err}, 32'd1);
    chk("R9 no done", {31'd0, g_done | done}, 32'd0);
    @(negedge clk);
    chk("R9 err cleared", {31'd0, err}, 32'd0);
    chk("R9 ready again", {31'd0, trap_ready}, 32'd1);
    chk("R9 no stack writes", wr_n - b_wr, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) code_mem[i] = '0;
    for (int i = 0; i < 512; i++) tab_mem[i] = '0;
    // even PC, no operands: op A5
    code_mem[8'h10] = 16'hA53C; tab_mem[9'h14A] = 16'h1234; tab_mem[9'h14B] = 16'h0003;
    // odd PC, one operand crossing: op 7B, operand C8
    code_mem[8'h20] = 16'h117B; code_mem[8'h21] = 16'hC899;
    tab_mem[9'h0F6] = 16'hBEEF; tab_mem[9'h0F7] = 16'h0102;
    // even PC, one operand in same word: op 5A, operand E1
    code_mem[8'h30] = 16'h5AE1; tab_mem[9'h0B4] = 16'h0042; tab_mem[9'h0B5] = 16'h0100;
    // even PC, two operands: op 33, operands 44 55
    code_mem[8'h40] = 16'h3344; code_mem[8'h41] = 16'h5566;
    tab_mem[9'h066] = 16'h7777; tab_mem[9'h067] = 16'h0205;
    // odd PC, two operands: op 2D, operands 9A BC
    code_mem[8'h50] = 16'h002D; code_mem[8'h51] = 16'h9ABC;
    tab_mem[9'h05A] = 16'h0F0F; tab_mem[9'h05B] = 16'h0200;
    // illegal count: op 3E
    code_mem[8'h60] = 16'h3E00; tab_mem[9'h07C] = 16'h1111; tab_mem[9'h07D] = 16'h0301;

    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    legal_case("even pc, none",     16'h0020, 16'h0100, 8'hA5, 16'h1234, 8'h03, 0, 16'h0000, 1);
    legal_case("odd pc, one",       16'h0041, 16'h0100, 8'h7B, 16'hBEEF, 8'h02, 1, 16'h00C8, 2);
    legal_case("even pc, one",      16'h0060, 16'h0200, 8'h5A, 16'h0042, 8'h00, 1, 16'h00E1, 1);
    stall = 1'b1;
    legal_case("even pc, two, stalled", 16'h0080, 16'h0210, 8'h33, 16'h7777, 8'h05, 2, 16'h4455, 2);
    legal_case("odd pc, two, stalled",  16'h00A1, 16'h0220, 8'h2D, 16'h0F0F, 8'h00, 2, 16'h9ABC, 2);
    stall = 1'b0;
    t_illegal();
    legal_case("after error",       16'h0020, 16'h0400, 8'hA5, 16'h1234, 8'h03, 0, 16'h0000, 1);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule